// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block lets an outside bus master borrow the external address/data bus and the strobe lines from the local bus-cycle sequencer. The outside master raises an asynchronous hold request. The arbiter first brings that request into the bus clock domain. It then waits for a clean handover point. If a local bus cycle is running, that point is the end of the cycle. If the bus is idle, it is the next clock. At the handover point the arbiter turns off every output driver. Only after that does it raise hold-acknowledge.

While the hold lasts, the arbiter stalls the local sequencer so that no new cycle starts. When the request goes away, acknowledge drops first. The drivers come back one clock later, so the two masters never drive the bus at the same time.

The arbiter also produces one active-low chip select per memory block. A chip select follows the local cycle that addresses its block. It is forced inactive whenever the local side does not own the bus.

Top module: `busown_arbiter`

## Requirements
- R1: After reset, every address/data and strobe output enable is 1, every chip-select output enable is 1, hold_ack is 0, seq_stall is 0 and all cs_n bits are 1.
- R2: hold_req_async passes through SYNC_STAGES flip-flops before it is used. A request applied before edge 1 raises seq_stall after SYNC_STAGES edges, but the drivers stay enabled at that point.
- R3: If no local cycle is in progress, the drivers are disabled at the first edge after the synchronized request is seen. With the default of 2 stages, that is SYNC_STAGES+1 edges after the request.
- R4: If cyc_busy is 1 and cyc_done is 0, the drivers stay enabled and the current chip select stays active. The drivers turn off at the edge that samples cyc_done=1.
- R5: hold_ack rises exactly one edge after the drivers are disabled. It is never 1 while any address/data or strobe enable is 1.
- R6: seq_stall is 1 whenever the synchronized request is 1 or the arbiter is not idle. A cyc_start presented while seq_stall is 1 is ignored, so no chip select activates from it.
- R7: When the synchronized request drops during the hold, hold_ack falls at the next edge while the drivers stay off. The drivers turn back on one edge after that.
- R8: Chip selects follow local cycles. Block index cyc_blk=n (binary) drives bit n of cs_n low, starting at the edge that samples an accepted cyc_start. It stays low until the edge that samples cyc_done, unless a new accepted cyc_start at that edge replaces it. At most one bit is low, and all bits are 1 when no cycle is running or the bus is released.
- R9: While the local side owns the bus, strb_n equals loc_strb_n. While the bus is released, strb_n is all ones and strb_oe is all zeros.
- R10: If the request is withdrawn before acknowledge (while waiting for a cycle end), the arbiter returns to idle with the drivers enabled. In that case hold_ack never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_async | input | 1 | Hold request from the outside master, asynchronous |
| cyc_busy | input | 1 | Local bus cycle in progress |
| cyc_done | input | 1 | One-clock strobe marking the final clock of a local cycle |
| cyc_start | input | 1 | One-clock strobe: local sequencer starts a cycle |
| cyc_blk | input | BLK_W | Memory block index of the cycle being started |
| loc_strb_n | input | NSTRB | Active-low strobes from the local sequencer |
| ad_oe | output | AD_W | Per-line address/data output enables |
| strb_n | output | NSTRB | Active-low strobe outputs |
| strb_oe | output | NSTRB | Per-strobe output enables |
| cs_n | output | NBLK | Active-low chip selects, one per memory block |
| cs_oe | output | NBLK | Per-chip-select output enables |
| hold_ack | output | 1 | Hold acknowledge to the outside master |
| seq_stall | output | 1 | Stops the local sequencer from starting cycles |

## Verification
The handover is tried from three starting points. The first is an idle bus, which shows the release on the first edge after synchronization. The second is a bus held busy for several clocks before cyc_done, which shows that the release truly waits for the cycle end. The third is a request withdrawn while waiting, which separates an aborted request from a granted one.

Each grant is also undone, so the order of acknowledge fall and driver return is measured edge by edge. Chip-select patterns cover distinct block indices, a back-to-back start that coincides with a done, and a start offered during a stall. Together these separate correct index decoding from stuck or shifted bits and from starts that leak through the stall.

// File: rtl/busown_pkg.sv
`timescale 1ns/1ps
package busown_pkg;
   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_WAIT_END = 3'd1,
      ST_RELEASE  = 3'd2,
      ST_HOLD     = 3'd3,
      ST_RECLAIM  = 3'd4
   } own_state_t;
endpackage

// File: rtl/busown_sync.sv
`timescale 1ns/1ps
module busown_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("busown_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/busown_fsm.sv
`timescale 1ns/1ps
module busown_fsm
   import busown_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_s,
   input  logic       cyc_busy,
   input  logic       cyc_done,
   output own_state_t state,
   output logic       bus_own,
   output logic       hold_ack,
   output logic       stall
);
   own_state_t nxt;
   logic       cycle_open;

   assign cycle_open = cyc_busy && !cyc_done;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: begin
            if (req_s) nxt = cycle_open ? ST_WAIT_END : ST_RELEASE;
         end
         ST_WAIT_END: begin
            if (!req_s)        nxt = ST_IDLE;
            else if (cyc_done) nxt = ST_RELEASE;
         end
         ST_RELEASE: begin
            nxt = req_s ? ST_HOLD : ST_RECLAIM;
         end
         ST_HOLD: begin
            if (!req_s) nxt = ST_RECLAIM;
         end
         ST_RECLAIM: begin
            nxt = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   assign bus_own  = (state == ST_IDLE) || (state == ST_WAIT_END);
   assign hold_ack = (state == ST_HOLD);
   assign stall    = req_s || (state != ST_IDLE);

   // R5: acknowledge only rises after a cycle with the drivers off
   assert_ack_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_ack) |-> $past(!bus_own));

   // R7: drivers still off in the cycle acknowledge falls
   assert_ack_falls_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_ack) |-> !bus_own);

   // R4: the bus is only given up on a cycle boundary or an idle bus
   assert_release_on_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_own) |-> $past(!cyc_busy || cyc_done));

   // R6: the sequencer is held off for the whole grant
   assert_stall_in_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack |-> stall);
endmodule

// File: rtl/busown_cs_track.sv
`timescale 1ns/1ps
module busown_cs_track #(
   parameter int NBLK  = 4,
   parameter int BLK_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_ok,
   input  logic [BLK_W-1:0] blk,
   input  logic             done,
   output logic [NBLK-1:0]  cs_act
);
   for (genvar n = 0; n < NBLK; n++) begin : g_blk
      logic hit;
      assign hit = (blk == BLK_W'(n));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        cs_act[n] <= 1'b0;
         else if (start_ok) cs_act[n] <= hit;
         else if (done)     cs_act[n] <= 1'b0;
      end
   end

   // R8: never more than one block selected
   assert_cs_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_act));
endmodule

// File: rtl/busown_drive.sv
`timescale 1ns/1ps
module busown_drive #(
   parameter int AD_W  = 16,
   parameter int NSTRB = 4,
   parameter int NBLK  = 4
) (
   input  logic             bus_own,
   input  logic [NSTRB-1:0] loc_strb_n,
   input  logic [NBLK-1:0]  cs_act,
   output logic [AD_W-1:0]  ad_oe,
   output logic [NSTRB-1:0] strb_n,
   output logic [NSTRB-1:0] strb_oe,
   output logic [NBLK-1:0]  cs_n,
   output logic [NBLK-1:0]  cs_oe
);
   for (genvar i = 0; i < AD_W; i++) begin : g_ad
      assign ad_oe[i] = bus_own;
   end

   for (genvar i = 0; i < NSTRB; i++) begin : g_strb
      assign strb_oe[i] = bus_own;
      assign strb_n[i]  = bus_own ? loc_strb_n[i] : 1'b1;
   end

   for (genvar i = 0; i < NBLK; i++) begin : g_cs
      assign cs_oe[i] = bus_own;
      assign cs_n[i]  = !(bus_own && cs_act[i]);
   end
endmodule

// File: rtl/busown_arbiter.sv
`timescale 1ns/1ps
module busown_arbiter
   import busown_pkg::*;
#(
   parameter int AD_W        = 16,
   parameter int NSTRB       = 4,
   parameter int NBLK        = 4,
   parameter int SYNC_STAGES = 2,
   localparam int BLK_W      = (NBLK > 1) ? $clog2(NBLK) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_req_async,
   input  logic             cyc_busy,
   input  logic             cyc_done,
   input  logic             cyc_start,
   input  logic [BLK_W-1:0] cyc_blk,
   input  logic [NSTRB-1:0] loc_strb_n,
   output logic [AD_W-1:0]  ad_oe,
   output logic [NSTRB-1:0] strb_n,
   output logic [NSTRB-1:0] strb_oe,
   output logic [NBLK-1:0]  cs_n,
   output logic [NBLK-1:0]  cs_oe,
   output logic             hold_ack,
   output logic             seq_stall
);
   if (AD_W < 1 || NSTRB < 1 || NBLK < 1) begin : g_bad_width
      $error("busown_arbiter: widths and counts must be positive");
   end

   logic       req_s;
   logic       bus_own;
   logic       start_ok;
   own_state_t state;
   logic [NBLK-1:0] cs_act;

   busown_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (hold_req_async),
      .q_sync  (req_s)
   );

   busown_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_s    (req_s),
      .cyc_busy (cyc_busy),
      .cyc_done (cyc_done),
      .state    (state),
      .bus_own  (bus_own),
      .hold_ack (hold_ack),
      .stall    (seq_stall)
   );

   assign start_ok = cyc_start && !seq_stall;

   busown_cs_track #(.NBLK(NBLK), .BLK_W(BLK_W)) u_cs (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_ok (start_ok),
      .blk      (cyc_blk),
      .done     (cyc_done),
      .cs_act   (cs_act)
   );

   busown_drive #(.AD_W(AD_W), .NSTRB(NSTRB), .NBLK(NBLK)) u_drive (
      .bus_own    (bus_own),
      .loc_strb_n (loc_strb_n),
      .cs_act     (cs_act),
      .ad_oe      (ad_oe),
      .strb_n     (strb_n),
      .strb_oe    (strb_oe),
      .cs_n       (cs_n),
      .cs_oe      (cs_oe)
   );

   // R5: no acknowledge while any bus or strobe driver is on
   assert_ack_with_drivers_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack |-> (ad_oe == '0) && (strb_oe == '0));

   // R8: chip selects quiet whenever the bus is not owned
   assert_cs_quiet_when_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_oe == '0) |-> (cs_n == '1));

   // R9: released strobes read inactive
   assert_strobe_idle_when_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (strb_oe == '0) |-> (strb_n == '1));
endmodule

// File: tb/busown_arbiter_test.sv
`timescale 1ns/1ps
module busown_arbiter_test;
   localparam int AD_W = 16, NSTRB = 4, NBLK = 4, SYNC = 2, BLK_W = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic hold_req_async = 1'b0, cyc_busy = 1'b0, cyc_done = 1'b0, cyc_start = 1'b0;
   logic [BLK_W-1:0] cyc_blk = '0;
   logic [NSTRB-1:0] loc_strb_n = '1;
   logic [AD_W-1:0]  ad_oe;
   logic [NSTRB-1:0] strb_n, strb_oe;
   logic [NBLK-1:0]  cs_n, cs_oe;
   logic hold_ack, seq_stall;

   int errors = 0, checks = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   busown_arbiter #(.AD_W(AD_W), .NSTRB(NSTRB), .NBLK(NBLK), .SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .hold_req_async(hold_req_async),
      .cyc_busy(cyc_busy), .cyc_done(cyc_done), .cyc_start(cyc_start),
      .cyc_blk(cyc_blk), .loc_strb_n(loc_strb_n), .ad_oe(ad_oe),
      .strb_n(strb_n), .strb_oe(strb_oe), .cs_n(cs_n), .cs_oe(cs_oe),
      .hold_ack(hold_ack), .seq_stall(seq_stall)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   // R5 monitor: acknowledge must never overlap an enabled driver
   always @(negedge clk) begin
      if (rst_n && hold_ack && ((|ad_oe) || (|strb_oe))) begin
         errors++;
         $display("FAIL R5 overlap: ad_oe=%0h strb_oe=%0h expected=0", ad_oe, strb_oe);
      end
   end

   task automatic t_reset;
      chk("R1", "ad_oe", 32'(ad_oe), 32'hFFFF);
      chk("R1", "strb_oe", 32'(strb_oe), 32'hF);
      chk("R1", "cs_oe", 32'(cs_oe), 32'hF);
      chk("R1", "hold_ack", 32'(hold_ack), 0);
      chk("R1", "seq_stall", 32'(seq_stall), 0);
      chk("R1", "cs_n", 32'(cs_n), 32'hF);
   endtask

   task automatic t_strobe_pass;
      loc_strb_n = 4'b1010;
      #0.5;
      chk("R9", "strb_n owned", 32'(strb_n), 32'hA);
      loc_strb_n = 4'b0101;
      #0.5;
      chk("R9", "strb_n owned 2", 32'(strb_n), 32'h5);
      loc_strb_n = 4'b1111;
      tick(1);
   endtask

   task automatic t_chip_select;
      cyc_start = 1; cyc_blk = 2; cyc_busy = 1;
      tick(1);
      cyc_start = 0;
      chk("R8", "cs_n blk2", 32'(cs_n), 32'hB);
      tick(2);
      chk("R8", "cs_n held blk2", 32'(cs_n), 32'hB);
      cyc_done = 1; cyc_start = 1; cyc_blk = 0;
      tick(1);
      cyc_done = 0; cyc_start = 0;
      chk("R8", "cs_n back-to-back blk0", 32'(cs_n), 32'hE);
      cyc_done = 1; cyc_busy = 0;
      tick(1);
      cyc_done = 0;
      chk("R8", "cs_n after done", 32'(cs_n), 32'hF);
   endtask

   task automatic t_idle_hold;
      hold_req_async = 1;
      tick(SYNC);
      chk("R2", "stall after sync", 32'(seq_stall), 1);
      chk("R2", "drivers still on", 32'(ad_oe), 32'hFFFF);
      tick(1);
      chk("R3", "ad_oe released", 32'(ad_oe), 0);
      chk("R9", "strb_oe released", 32'(strb_oe), 0);
      chk("R9", "strb_n released", 32'(strb_n), 32'hF);
      chk("R5", "no ack yet", 32'(hold_ack), 0);
      tick(1);
      chk("R5", "ack", 32'(hold_ack), 1);
      cyc_start = 1; cyc_blk = 1;
      tick(1);
      cyc_start = 0;
      chk("R6", "start ignored in hold", 32'(cs_n), 32'hF);
      hold_req_async = 0;
      tick(SYNC);
      chk("R7", "ack still up before sync", 32'(hold_ack), 1);
      tick(1);
      chk("R7", "ack dropped", 32'(hold_ack), 0);
      chk("R7", "drivers still off", 32'(ad_oe), 0);
      tick(1);
      chk("R7", "drivers back", 32'(ad_oe), 32'hFFFF);
      chk("R7", "stall clear", 32'(seq_stall), 0);
      chk("R6", "ignored start left no select", 32'(cs_n), 32'hF);
   endtask

   task automatic t_busy_hold;
      cyc_start = 1; cyc_blk = 3; cyc_busy = 1;
      tick(1);
      cyc_start = 0;
      hold_req_async = 1;
      tick(SYNC + 4);
      chk("R4", "drivers kept in cycle", 32'(ad_oe), 32'hFFFF);
      chk("R4", "cs kept in cycle", 32'(cs_n), 32'h7);
      chk("R4", "no ack in cycle", 32'(hold_ack), 0);
      chk("R6", "stall while waiting", 32'(seq_stall), 1);
      cyc_done = 1;
      tick(1);
      cyc_done = 0; cyc_busy = 0;
      chk("R4", "released at done", 32'(ad_oe), 0);
      chk("R8", "cs off when released", 32'(cs_n), 32'hF);
      tick(1);
      chk("R5", "ack after busy release", 32'(hold_ack), 1);
      hold_req_async = 0;
      tick(SYNC + 2);
      chk("R7", "owned again", 32'(ad_oe), 32'hFFFF);
   endtask

   task automatic t_abort;
      cyc_start = 1; cyc_blk = 0; cyc_busy = 1;
      tick(1);
      cyc_start = 0;
      hold_req_async = 1;
      tick(SYNC + 2);
      hold_req_async = 0;
      tick(SYNC + 1);
      chk("R10", "drivers on after abort", 32'(ad_oe), 32'hFFFF);
      chk("R10", "no ack after abort", 32'(hold_ack), 0);
      tick(5);
      chk("R10", "ack never rose", 32'(hold_ack), 0);
      chk("R10", "stall clear", 32'(seq_stall), 0);
      cyc_done = 1;
      tick(1);
      cyc_done = 0; cyc_busy = 0;
   endtask

   initial begin
      #(4 * 100000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      tick(3);
      t_reset();
      rst_n = 1;
      tick(1);
      t_strobe_pass();
      t_chip_select();
      t_idle_hold();
      t_busy_hold();
      t_abort();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule